// File: doc/BRIEF.md
# LCD Frame Timing and Pin Function Controller

This block turns the decoded control fields of a small LCD driver into timing and pin settings. A three-bit rate code selects one of five frame periods, all multiples of a base step, so the frame strobe divides the oscillator by 8, 6, 4, 3 or 2 steps. With the default step of 96 cycles the ratios are 768, 576, 384, 288 and 192. A duty flag chooses between static drive and half-duty drive. Static drive holds the second common line idle, and half-duty drive lets it run.

A three-bit pin code turns a leading run of the shared pins, counted from pin 0, into general-purpose outputs. Each such pin then carries one display data bit. Which bit it carries depends on the drive mode. The remaining pins stay on segment drive.

A compact-format input overrides the stored fields. While it is high, the block uses the middle ratio, half-duty drive and segment drive on every pin. Settings take effect one clock after the inputs change. The frame divider restarts its count whenever the ratio in effect changes.

Top module: `lcd_frame_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high) clears `com2_drive`, `pin_gpo`, `pin_level` and `frame_tick` and selects the 4-step ratio. After `rst` falls, while the ratio stays the 4-step one, the first `frame_tick` comes exactly 4*UNIT clocks later.
- R2: With `compact_fmt` low, the `rate_code` values give these frame periods between successive `frame_tick` pulses: 3'b110 gives 8*UNIT, 3'b111 gives 6*UNIT, 3'b000 gives 4*UNIT, 3'b001 gives 3*UNIT and 3'b010 gives 2*UNIT clocks.
- R3: The unlisted `rate_code` values 3'b011, 3'b100 and 3'b101 give the 4*UNIT period.
- R4: `frame_tick` is high for exactly one clock per frame.
- R5: When the ratio in effect changes, the divider restarts its count. If the new code is applied in the clock where a tick is seen, the next tick comes new_period+2 clocks later.
- R6: `com2_drive` equals `duty_sel OR compact_fmt` from the previous clock. 0 means static drive with the second common line idle, and 1 means half-duty drive.
- R7: `pin_sel` values 3'b001, 3'b010, 3'b011 and 3'b100 set `pin_gpo` to 4'b0001, 4'b0011, 4'b0111 and 4'b1111, one clock later. 3'b000 gives 4'b0000. A set bit marks a general-purpose pin.
- R8: `pin_sel` values 3'b101, 3'b110 and 3'b111 leave every pin on segment drive (`pin_gpo` = 0).
- R9: A general-purpose pin i drives `disp_bits[i]` in static drive and `disp_bits[2*i]` in half-duty drive, where bit 0 is the first display bit. A pin on segment drive shows `pin_level` 0.
- R10: While `compact_fmt` is high, the block ignores `rate_code`, `duty_sel` and `pin_sel`. It uses the 4*UNIT period, half-duty drive and segment drive on every pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_code | input | 3 | Frame ratio code |
| duty_sel | input | 1 | 0 static drive, 1 half-duty drive |
| pin_sel | input | 3 | Count code for general-purpose pins |
| compact_fmt | input | 1 | Compact-format override |
| disp_bits | input | 2*PINS | Display data, bit 0 first |
| frame_tick | output | 1 | One-clock frame strobe |
| com2_drive | output | 1 | Second common line active |
| pin_gpo | output | PINS | Pin is a general-purpose output |
| pin_level | output | PINS | Level driven by general-purpose pins |

## Verification
The bench builds the block with UNIT=3 and PINS=4. The five frame periods then shrink to 24, 18, 12, 9 and 6 clocks. Every rate code, the restart on a ratio change and the override can therefore be timed to the exact clock within a few hundred cycles. Four pins are enough to reach every step of the pin-count code, and a display pattern is chosen so that the static and half-duty bit choices give different levels.

// File: rtl/lcd_frame_pkg.sv
package lcd_frame_pkg;

   typedef logic [3:0] mult_t;

   localparam mult_t MULT_DEFAULT = 4'd4;

   // Ratio multiple of the base step for a rate code; unlisted codes fall back
   function automatic mult_t rate_mult(input logic [2:0] code);
      mult_t m;
      case (code)
         3'b110:  m = 4'd8;
         3'b111:  m = 4'd6;
         3'b000:  m = 4'd4;
         3'b001:  m = 4'd3;
         3'b010:  m = 4'd2;
         default: m = MULT_DEFAULT;
      endcase
      return m;
   endfunction

   // Number of leading pins given to general-purpose use
   function automatic logic [2:0] gpo_count(input logic [2:0] sel);
      logic [2:0] n;
      case (sel)
         3'b001:  n = 3'd1;
         3'b010:  n = 3'd2;
         3'b011:  n = 3'd3;
         3'b100:  n = 3'd4;
         default: n = 3'd0;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/lcd_rate_decode.sv
module lcd_rate_decode
   import lcd_frame_pkg::*;
(
   input  logic [2:0] rate_code,
   input  logic       compact_fmt,
   output mult_t      mult
);

   always_comb begin
      if (compact_fmt) mult = MULT_DEFAULT;
      else             mult = rate_mult(rate_code);
   end

endmodule

// File: rtl/lcd_frame_div.sv
module lcd_frame_div
   import lcd_frame_pkg::*;
#(
   parameter int UNIT = 96
) (
   input  logic  clk,
   input  logic  rst,
   input  mult_t mult,
   output logic  frame_tick
);

   localparam int MAX_LIM = 8 * UNIT;
   localparam int CNT_W   = $clog2(MAX_LIM + 1);

   generate
      if (UNIT < 1) begin : g_bad_unit
         $error("lcd_frame_div: UNIT must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;
   mult_t            mult_d;
   logic             restart;

   assign lim     = CNT_W'(int'(mult) * UNIT);
   assign restart = (mult != mult_d);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt        <= '0;
         mult_d     <= MULT_DEFAULT;
         frame_tick <= 1'b0;
      end else begin
         mult_d <= mult;
         if (restart) begin
            cnt        <= '0;
            frame_tick <= 1'b0;
         end else if (cnt == lim - CNT_W'(1)) begin
            cnt        <= '0;
            frame_tick <= 1'b1;
         end else begin
            cnt        <= cnt + CNT_W'(1);
            frame_tick <= 1'b0;
         end
      end
   end

   // R4: strobe lasts a single clock
   a_r4_tick_single: assert property (@(posedge clk) disable iff (rst)
      frame_tick |=> !frame_tick);

   // R2: with a settled ratio the count stays below its limit
   a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
      (mult == mult_d) |-> (cnt < lim));

   // R5: a ratio change clears the count on the next clock
   a_r5_restart: assert property (@(posedge clk) disable iff (rst)
      (mult != mult_d) |=> (cnt == '0 && !frame_tick));

endmodule

// File: rtl/lcd_pin_router.sv
module lcd_pin_router
   import lcd_frame_pkg::*;
#(
   parameter int PINS = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [2:0]        pin_sel,
   input  logic              compact_fmt,
   input  logic              half_eff,
   input  logic [2*PINS-1:0] disp_bits,
   output logic [PINS-1:0]   pin_gpo,
   output logic [PINS-1:0]   pin_level
);

   generate
      if (PINS < 1 || PINS > 4) begin : g_bad_pins
         $error("lcd_pin_router: PINS must be between 1 and 4");
      end
   endgenerate

   logic [2:0]      n_gpo;
   logic [PINS-1:0] nxt_gpo;
   logic [PINS-1:0] nxt_lvl;

   assign n_gpo = compact_fmt ? 3'd0 : gpo_count(pin_sel);

   genvar i;
   generate
      for (i = 0; i < PINS; i++) begin : g_pin
         logic src;
         assign src        = half_eff ? disp_bits[2*i] : disp_bits[i];
         assign nxt_gpo[i] = (n_gpo > 3'(i));
         assign nxt_lvl[i] = nxt_gpo[i] & src;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         pin_gpo   <= '0;
         pin_level <= '0;
      end else begin
         pin_gpo   <= nxt_gpo;
         pin_level <= nxt_lvl;
      end
   end

   // R9: segment pins never show a level
   a_r9_seg_quiet: assert property (@(posedge clk) disable iff (rst)
      (pin_level & ~pin_gpo) == '0);

   // R7: general-purpose pins always form a leading run
   a_r7_thermo: assert property (@(posedge clk) disable iff (rst)
      (pin_gpo & (pin_gpo + PINS'(1))) == '0);

   // R10: override forces segment drive
   a_r10_all_seg: assert property (@(posedge clk) disable iff (rst)
      compact_fmt |=> (pin_gpo == '0));

   // R8: unlisted codes keep every pin on segment drive
   a_r8_unlisted: assert property (@(posedge clk) disable iff (rst)
      (pin_sel inside {3'b101, 3'b110, 3'b111}) |=> (pin_gpo == '0));

endmodule

// File: rtl/lcd_frame_ctrl.sv
module lcd_frame_ctrl
   import lcd_frame_pkg::*;
#(
   parameter int UNIT = 96,
   parameter int PINS = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [2:0]        rate_code,
   input  logic              duty_sel,
   input  logic [2:0]        pin_sel,
   input  logic              compact_fmt,
   input  logic [2*PINS-1:0] disp_bits,
   output logic              frame_tick,
   output logic              com2_drive,
   output logic [PINS-1:0]   pin_gpo,
   output logic [PINS-1:0]   pin_level
);

   mult_t mult_nxt;
   mult_t mult_q;
   logic  half_eff;

   assign half_eff = compact_fmt | duty_sel;

   lcd_rate_decode u_decode (
      .rate_code   (rate_code),
      .compact_fmt (compact_fmt),
      .mult        (mult_nxt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         mult_q     <= MULT_DEFAULT;
         com2_drive <= 1'b0;
      end else begin
         mult_q     <= mult_nxt;
         com2_drive <= half_eff;
      end
   end

   lcd_frame_div #(.UNIT(UNIT)) u_div (
      .clk        (clk),
      .rst        (rst),
      .mult       (mult_q),
      .frame_tick (frame_tick)
   );

   lcd_pin_router #(.PINS(PINS)) u_pins (
      .clk         (clk),
      .rst         (rst),
      .pin_sel     (pin_sel),
      .compact_fmt (compact_fmt),
      .half_eff    (half_eff),
      .disp_bits   (disp_bits),
      .pin_gpo     (pin_gpo),
      .pin_level   (pin_level)
   );

   // R10: override forces half duty and the middle ratio
   a_r10_force_half: assert property (@(posedge clk) disable iff (rst)
      compact_fmt |=> com2_drive);

   a_r10_force_rate: assert property (@(posedge clk) disable iff (rst)
      compact_fmt |=> (mult_q == MULT_DEFAULT));

   // R6: static drive keeps the second common line idle
   a_r6_static_idle: assert property (@(posedge clk) disable iff (rst)
      (!compact_fmt && !duty_sel) |=> !com2_drive);

   // R3: unlisted rate codes fall back to the middle ratio
   a_r3_unlisted: assert property (@(posedge clk) disable iff (rst)
      (!compact_fmt && (rate_code inside {3'b011, 3'b100, 3'b101}))
      |=> (mult_q == MULT_DEFAULT));

endmodule

// File: tb/lcd_frame_ctrl_test.sv
module lcd_frame_ctrl_test;

   localparam int PERIOD = 10;
   localparam int UNIT   = 3;
   localparam int PINS   = 4;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] rate_code = 3'b000;
   logic       duty_sel = 1'b1;
   logic [2:0] pin_sel = 3'b100;
   logic       compact_fmt = 1'b0;
   logic [7:0] disp_bits = 8'hFF;
   logic       frame_tick;
   logic       com2_drive;
   logic [3:0] pin_gpo;
   logic [3:0] pin_level;

   int n_checks = 0;
   int n_fail   = 0;

   typedef struct {
      string      req;
      logic       half;
      logic [3:0] gpo;
      logic [3:0] lvl;
   } exp_t;

   exp_t q[$];

   always #(PERIOD/2) clk = ~clk;

   lcd_frame_ctrl #(.UNIT(UNIT), .PINS(PINS)) uut (
      .clk(clk), .rst(rst), .rate_code(rate_code), .duty_sel(duty_sel),
      .pin_sel(pin_sel), .compact_fmt(compact_fmt), .disp_bits(disp_bits),
      .frame_tick(frame_tick), .com2_drive(com2_drive),
      .pin_gpo(pin_gpo), .pin_level(pin_level)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   // Driver: apply inputs and push the expected settings
   task automatic apply(input string req, input logic d, input logic [2:0] ps,
                        input logic cf, input logic [7:0] db);
      exp_t e;
      int   n;
      @(negedge clk);
      duty_sel = d; pin_sel = ps; compact_fmt = cf; disp_bits = db;
      e.req  = req;
      e.half = cf | d;
      n = cf ? 0 : (ps == 3'd1 ? 1 : ps == 3'd2 ? 2 : ps == 3'd3 ? 3 : ps == 3'd4 ? 4 : 0);
      for (int i = 0; i < 4; i++) begin
         e.gpo[i] = (i < n);
         e.lvl[i] = e.gpo[i] & (e.half ? db[2*i] : db[i]);
      end
      q.push_back(e);
   endtask

   // Monitor: compare one registered result per queued item
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         chk(e.req, int'({com2_drive, pin_gpo, pin_level}), int'({e.half, e.gpo, e.lvl}));
      end
   end

   task automatic wait_tick(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!frame_tick && n < 400);
   endtask

   task automatic measure(input string req, input int lim);
      int n;
      wait_tick(n);
      @(negedge clk);
      chk("R4", int'(frame_tick), 0);
      n = 1;
      while (!frame_tick && n < 400) begin
         @(negedge clk);
         n++;
      end
      chk(req, n, lim);
   endtask

   initial begin
      #(PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      summary();
      $finish;
   end

   initial begin
      int n;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", int'({frame_tick, com2_drive, pin_gpo, pin_level}), 0);
      rst = 1'b0;
      wait_tick(n);
      chk("R1", n, 4*UNIT);

      // R2: listed codes
      rate_code = 3'b110; measure("R2", 8*UNIT);
      rate_code = 3'b111; measure("R2", 6*UNIT);
      rate_code = 3'b000; measure("R2", 4*UNIT);
      rate_code = 3'b001; measure("R2", 3*UNIT);
      rate_code = 3'b010; measure("R2", 2*UNIT);
      // R3: unlisted codes
      rate_code = 3'b011; measure("R3", 4*UNIT);
      rate_code = 3'b100; measure("R3", 4*UNIT);
      rate_code = 3'b101; measure("R3", 4*UNIT);

      // R5: restart on ratio change, applied in the tick clock
      wait_tick(n);
      rate_code = 3'b010;
      wait_tick(n);
      chk("R5", n, 2*UNIT + 2);
      wait_tick(n);
      rate_code = 3'b110;
      wait_tick(n);
      chk("R5", n, 8*UNIT + 2);

      // R10: override ignores the rate code
      compact_fmt = 1'b1;
      measure("R10", 4*UNIT);
      compact_fmt = 1'b0;

      // R6: duty selection
      apply("R6", 1'b0, 3'b000, 1'b0, 8'hA5);
      apply("R6", 1'b1, 3'b000, 1'b0, 8'hA5);
      // R7 and R9: pin counts, static and half duty
      for (int s = 0; s <= 4; s++) begin
         apply("R7", 1'b0, 3'(s), 1'b0, 8'hA5);
         apply("R9", 1'b1, 3'(s), 1'b0, 8'hA5);
      end
      apply("R9", 1'b0, 3'b100, 1'b0, 8'h5A);
      apply("R9", 1'b1, 3'b100, 1'b0, 8'h5A);
      // R8: unlisted pin codes
      for (int s = 5; s <= 7; s++) apply("R8", 1'b1, 3'(s), 1'b0, 8'hFF);
      // R10: override ignores duty and pin codes
      apply("R10", 1'b0, 3'b100, 1'b1, 8'hFF);
      apply("R10", 1'b0, 3'b011, 1'b1, 8'h0F);
      apply("R9", 1'b0, 3'b100, 1'b0, 8'h0F);

      repeat (3) @(negedge clk);
      summary();
      $finish;
   end

endmodule